// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire serial protocol engine in a small byte-addressed storage device. During a write session the engine hands it a word address and then a stream of data-byte strobes. The bytes land in a page-sized staging buffer instead of going straight to the storage array. Within a session the upper address bits, which select the page, stay fixed. The lower bits advance once per byte and wrap around inside the page. A byte that lands on a slot already filled earlier in the same session replaces the older value.

When the engine reports the STOP event, every slot loaded in the session is copied into the array in one timed write cycle. While that cycle runs, `busy` stays high for a fixed number of system clocks. The engine uses this flag to refuse new transfers. A STOP that has no loaded bytes does not start a cycle. If the engine rejects the session for write protection, it raises an abort, which drops everything loaded so far. The array comes out of reset with every byte at FFh. A separate read port returns array contents one clock after the address is presented. During a commit it keeps returning the old contents until the cycle ends.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset `busy` is 0 and every array address reads FFh.
- R2: A data strobe accepted while idle stores `wr_data` at buffer slot `off`. An address load sets the page to `addr_in[7:4]` and `off` to `addr_in[3:0]`. If the load and a strobe fall in the same cycle, the strobe uses the newly loaded offset. Each stored byte advances `off` by one, wrapping from 15 to 0, and the page does not change.
- R3: When a session writes a slot a second time, the later byte is the one committed.
- R4: A STOP while idle, with no abort and at least one loaded byte, raises `busy` on the next clock and keeps it high for exactly `WR_CYCLES` clocks. A byte strobed in the same cycle as the STOP counts as loaded and is committed with the others.
- R5: When `busy` falls, each loaded slot s has been written to array address {page, s}. All other addresses keep their values.
- R6: While `busy` is high, reads return the contents the array had before the commit.
- R7: A STOP with no loaded byte leaves `busy` low and the array unchanged.
- R8: `session_abort` while idle discards every loaded byte. It overrides a strobe in the same cycle and stops a STOP in the same cycle from starting a commit.
- R9: While `busy` is high, strobes, address loads, aborts and STOPs have no effect on the array or on later sessions.
- R10: With the default registered read mode, `rd_data` equals the array byte at `rd_addr` as sampled on the previous clock.
- R11: The loaded marks clear when a commit finishes, so a later session changes only the slots it loads itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr_load | input | 1 | Load the word address from `addr_in` |
| addr_in | input | ADDR_W | Word address: page in the upper bits, slot in the low PAGE_W bits |
| wr_strobe | input | 1 | One received data byte |
| wr_data | input | DATA_W | Data byte for `wr_strobe` |
| session_abort | input | 1 | Discard the current session (write-protect rejection) |
| stop_evt | input | 1 | STOP seen on the bus; commit the session |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array contents at the read address |
| busy | output | 1 | Write cycle in progress |

## Verification
The close call is the last data byte of a session and the STOP arriving in the same clock. The byte must still reach the buffer, and it must count towards deciding whether a write cycle starts at all. The bench provokes this by loading a single byte, then strobing a second byte together with the STOP. It then checks that both bytes appear after the cycle. A second pairing puts an abort in the same clock as a strobe or a STOP, and the bench judges it by seeing no busy period and unchanged array contents. A behavioural model steps through every clock alongside the design, and `busy` and `rd_data` are compared against it on every cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [0:0] {
      RD_COMB = 1'b0,
      RD_REG  = 1'b1
   } rd_mode_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pcc_page_buf.sv
module pcc_page_buf #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              accept,
   input  logic                              addr_load,
   input  logic [ADDR_W-1:0]                 addr_in,
   input  logic                              wr_strobe,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              abort,
   input  logic                              clear,
   output logic [ADDR_W-PAGE_W-1:0]          page_q,
   output logic [(1<<PAGE_W)*DATA_W-1:0]     data_flat,
   output logic [(1<<PAGE_W)-1:0]            vld_q,
   output logic                              any_after
);

   localparam int PB   = 1 << PAGE_W;
   localparam int PG_W = ADDR_W - PAGE_W;

   logic [PAGE_W-1:0] off_q;
   logic [PAGE_W-1:0] eff_off;
   logic              take;
   logic              drop;
   logic [PB-1:0]     hit;

   // a strobe is taken only while idle and not overridden by an abort
   assign take      = accept & wr_strobe & ~abort;
   assign drop      = accept & abort;
   assign eff_off   = (accept & addr_load) ? addr_in[PAGE_W-1:0] : off_q;
   assign any_after = (|vld_q) | take;

   always_comb begin
      hit = '0;
      if (take) begin
         hit[eff_off] = 1'b1;
      end
   end

   // page and slot pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= '0;
         page_q <= '0;
      end else if (accept) begin
         if (addr_load) begin
            page_q <= addr_in[ADDR_W-1:PAGE_W];
         end
         off_q <= take ? eff_off + 1'b1 : eff_off;
      end
   end

   // staging slots and their loaded marks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_flat <= '0;
         vld_q     <= '0;
      end else begin
         for (int s = 0; s < PB; s++) begin
            if (hit[s]) begin
               data_flat[s*DATA_W +: DATA_W] <= wr_data;
            end
            if (clear || drop) begin
               vld_q[s] <= 1'b0;
            end else if (hit[s]) begin
               vld_q[s] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pcc_commit_timer.sv
module pcc_commit_timer #(
   parameter int WR_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int CNT_W = pcc_pkg::cnt_bits(WR_CYCLES);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WR_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD_VAL;
         end
      end else if (cnt_q == '0) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pcc_array.sv
module pcc_array
   import pcc_pkg::*;
#(
   parameter int       ADDR_W  = 8,
   parameter int       DATA_W  = 8,
   parameter int       PAGE_W  = 4,
   parameter rd_mode_e RD_MODE = RD_REG
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           commit_en,
   input  logic [ADDR_W-PAGE_W-1:0]       commit_page,
   input  logic [(1<<PAGE_W)*DATA_W-1:0]  commit_data,
   input  logic [(1<<PAGE_W)-1:0]         commit_mask,
   input  logic [ADDR_W-1:0]              rd_addr,
   output logic [DATA_W-1:0]              rd_data
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int PB    = 1 << PAGE_W;

   logic [DEPTH-1:0][DATA_W-1:0] cells;

   // whole page written in one clock, only the marked slots
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '1;
      end else if (commit_en) begin
         for (int s = 0; s < PB; s++) begin
            if (commit_mask[s]) begin
               cells[{commit_page, PAGE_W'(s)}] <= commit_data[s*DATA_W +: DATA_W];
            end
         end
      end
   end

   generate
      if (RD_MODE == RD_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q <= '1;
            end else begin
               rd_q <= cells[rd_addr];
            end
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = cells[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
   import pcc_pkg::*;
#(
   parameter int       ADDR_W    = 8,
   parameter int       DATA_W    = 8,
   parameter int       PAGE_W    = 4,
   parameter int       WR_CYCLES = 64,
   parameter rd_mode_e RD_MODE   = RD_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              wr_strobe,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              session_abort,
   input  logic              stop_evt,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);

   localparam int PB   = 1 << PAGE_W;
   localparam int PG_W = ADDR_W - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("page_commit_ctrl: PAGE_W must lie in 1..ADDR_W-1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("page_commit_ctrl: DATA_W must be at least 1");
      end
      if (WR_CYCLES < 1) begin : g_bad_cycles
         $error("page_commit_ctrl: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic                 busy_w;
   logic                 done_w;
   logic                 start_w;
   logic                 any_after;
   logic [PG_W-1:0]      page_q;
   logic [PB*DATA_W-1:0] data_flat;
   logic [PB-1:0]        vld_q;

   assign start_w = stop_evt & ~busy_w & ~session_abort & any_after;
   assign busy    = busy_w;

   pcc_page_buf #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) i_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (~busy_w),
      .addr_load (addr_load),
      .addr_in   (addr_in),
      .wr_strobe (wr_strobe),
      .wr_data   (wr_data),
      .abort     (session_abort),
      .clear     (done_w),
      .page_q    (page_q),
      .data_flat (data_flat),
      .vld_q     (vld_q),
      .any_after (any_after)
   );

   pcc_commit_timer #(
      .WR_CYCLES (WR_CYCLES)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_w),
      .busy  (busy_w),
      .done  (done_w)
   );

   pcc_array #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PAGE_W  (PAGE_W),
      .RD_MODE (RD_MODE)
   ) i_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_en   (done_w),
      .commit_page (page_q),
      .commit_data (data_flat),
      .commit_mask (vld_q),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );

endmodule

// File: rtl/pcc_chk.sv
module pcc_chk
   import pcc_pkg::*;
#(
   parameter int       ADDR_W    = 8,
   parameter int       DATA_W    = 8,
   parameter int       PB        = 16,
   parameter int       WR_CYCLES = 64,
   parameter rd_mode_e RD_MODE   = RD_REG
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_evt,
   input logic              wr_strobe,
   input logic              session_abort,
   input logic              busy,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [PB-1:0]     vld
);

   logic [31:0] blen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blen_q <= '0;
      end else begin
         blen_q <= busy ? blen_q + 32'd1 : 32'd0;
      end
   end

   // R4: busy lasts exactly the write-cycle length
   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> blen_q == 32'(WR_CYCLES));

   // R4: a STOP together with a fresh byte starts the cycle
   p_stop_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wr_strobe && !session_abort && !busy) |=> busy);

   // R7: nothing loaded, no cycle
   p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !wr_strobe && !busy && vld == '0) |=> !busy);

   // R8: an abort cancels a STOP in the same cycle
   p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && session_abort && !busy) |=> !busy);

   // R2: an accepted strobe leaves a loaded mark
   p_strobe_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !session_abort && !busy) |=> vld != '0);

   // R9: marks frozen during the write cycle
   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(vld));

   // R11: marks empty once the cycle ends
   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> vld == '0);

   generate
      if (RD_MODE == RD_REG) begin : g_rd_chk
         // R6: array content does not move under a steady read during busy
         p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && $past(busy) && $past(rd_addr) == $past(rd_addr, 2))
            |-> $stable(rd_data));
      end
   endgenerate

endmodule

bind page_commit_ctrl pcc_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PB        (PB),
   .WR_CYCLES (WR_CYCLES),
   .RD_MODE   (RD_MODE)
) i_pcc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stop_evt      (stop_evt),
   .wr_strobe     (wr_strobe),
   .session_abort (session_abort),
   .busy          (busy),
   .rd_addr       (rd_addr),
   .rd_data       (rd_data),
   .vld           (vld_q)
);

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;

   localparam int WRC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [7:0] addr_in = '0;
   logic       wr_strobe = 1'b0;
   logic [7:0] wr_data = '0;
   logic       session_abort = 1'b0;
   logic       stop_evt = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       busy;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   int    sweep = 0;
   int    cyc_cnt = 0;

   // behavioural reference state
   int mem [256];
   int bufm [16];
   bit vm [16];
   int page_m = 0;
   int off_m = 0;
   int rem = 0;
   int exp_rd = 255;
   bit exp_busy = 1'b0;

   page_commit_ctrl #(
      .WR_CYCLES (WRC)
   ) i_page_commit_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr_load     (addr_load),
      .addr_in       (addr_in),
      .wr_strobe     (wr_strobe),
      .wr_data       (wr_data),
      .session_abort (session_abort),
      .stop_evt      (stop_evt),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data),
      .busy          (busy)
   );

   always #10 clk = ~clk;

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
         errors++;
         $display("FAIL watchdog expired: got running expected finished");
         summary();
      end
   end

   task automatic model_step();
      int  nrd;
      int  eff;
      bit  any;
      nrd = mem[rd_addr];
      if (rem > 0) begin
         rem--;
         if (rem == 0) begin
            for (int i = 0; i < 16; i++) begin
               if (vm[i]) mem[page_m*16 + i] = bufm[i];
               vm[i] = 1'b0;
            end
         end
      end else begin
         eff = addr_load ? int'(addr_in) % 16 : off_m;
         if (addr_load) page_m = int'(addr_in) / 16;
         if (session_abort) begin
            for (int i = 0; i < 16; i++) vm[i] = 1'b0;
            off_m = eff;
         end else if (wr_strobe) begin
            bufm[eff] = int'(wr_data);
            vm[eff] = 1'b1;
            off_m = (eff + 1) % 16;
         end else begin
            off_m = eff;
         end
         any = 1'b0;
         for (int i = 0; i < 16; i++) any |= vm[i];
         if (stop_evt && !session_abort && any) rem = WRC;
      end
      exp_rd = nrd;
      exp_busy = (rem > 0);
   endtask

   task automatic compare();
      checks++;
      if (busy !== exp_busy) begin
         errors++;
         $display("FAIL %s busy: got %0d expected %0d", tag, busy, exp_busy);
      end
      checks++;
      if (rd_data !== 8'(exp_rd)) begin
         errors++;
         $display("FAIL %s rd_data: got %0h expected %0h", tag, rd_data, exp_rd);
      end
   endtask

   task automatic drive(input bit ld, input int a, input bit st, input int d,
                        input bit ab, input bit sp, input int ra);
      @(negedge clk);
      compare();
      addr_load     = ld;
      addr_in       = 8'(a);
      wr_strobe     = st;
      wr_data       = 8'(d);
      session_abort = ab;
      stop_evt      = sp;
      rd_addr       = 8'(ra);
      model_step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         drive(0, 0, 0, 0, 0, 0, sweep);
         sweep = (sweep + 1) % 256;
      end
   endtask

   task automatic hold(input int n, input int ra);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, ra);
   endtask

   task automatic read_page(input int p);
      for (int i = 0; i < 16; i++) drive(0, 0, 0, 0, 0, 0, p*16 + i);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 255;
      for (int i = 0; i < 16; i++) begin
         bufm[i] = 0;
         vm[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_step();

      // R1: reset state over the whole array
      tag = "R1";
      idle(258);

      // R4 / R6 / R5: single byte behaves as a page of one
      tag = "R4";
      drive(1, 'h35, 1, 'hAA, 0, 0, 'h35);
      drive(0, 0, 0, 0, 0, 1, 'h35);
      tag = "R6";
      hold(WRC - 1, 'h35);
      tag = "R5";
      hold(4, 'h35);
      read_page(3);

      // R2: wrap inside the page
      tag = "R2";
      drive(1, 'h7E, 1, 'h01, 0, 0, 0);
      for (int i = 2; i <= 5; i++) drive(0, 0, 1, i, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 'h7E);
      hold(WRC + 2, 'h70);
      read_page(7);
      read_page(8);

      // R3: eighteen bytes, first two slots overwritten
      tag = "R3";
      drive(1, 'h90, 1, 'h40, 0, 0, 0);
      for (int i = 1; i < 18; i++) drive(0, 0, 1, 'h40 + i, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 0);
      hold(WRC + 2, 'h91);
      read_page(9);

      // R7: address-only session then STOP
      tag = "R7";
      drive(1, 'h20, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 'h20);
      idle(4);
      read_page(2);

      // R8: abort with STOP, abort with strobe
      tag = "R8";
      drive(1, 'hA0, 1, 'h11, 0, 0, 0);
      drive(0, 0, 1, 'h12, 0, 0, 0);
      drive(0, 0, 1, 'h13, 1, 1, 0);
      idle(3);
      drive(0, 0, 0, 0, 0, 1, 0);
      idle(3);
      drive(1, 'hA4, 1, 'h14, 1, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 0);
      idle(3);
      read_page(10);

      // R9: activity during busy is ignored
      tag = "R9";
      drive(1, 'hC3, 1, 'h5A, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 0);
      drive(1, 'hD0, 1, 'h77, 0, 0, 'hC3);
      drive(0, 0, 1, 'h78, 0, 1, 'hD1);
      drive(0, 0, 1, 'h79, 1, 0, 'hD2);
      drive(1, 'hD8, 0, 0, 0, 1, 'hD8);
      hold(WRC, 'hC3);
      read_page(12);
      read_page(13);

      // R11: new session only changes its own slot
      tag = "R11";
      drive(1, 'hD5, 1, 'h22, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1, 0);
      hold(WRC + 2, 'hD3);
      read_page(13);

      // R4: last byte and STOP in the same clock
      tag = "R4";
      drive(1, 'hE0, 1, 'h55, 0, 0, 0);
      drive(0, 0, 1, 'h66, 0, 1, 'hE1);
      hold(WRC + 2, 'hE1);
      read_page(14);

      // R10: full read sweep with one-clock latency
      tag = "R10";
      idle(258);

      summary();
   end

endmodule